// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a decoded switching command into the two gate enables of a synchronous buck power stage: one for the high-side switch and one for the low-side switch. It does not use a fixed dead band. Before a turn-on, it waits until a sensed flag reports that the opposite switch is really off, and then waits a programmed number of clock cycles. The high side waits for the low-side gate to read as discharged. The low side waits for the switch node to read as fallen. If the switch node never reports, a backup timer started by the high-side-gate-discharged flag lets the low side turn on anyway.

Several inputs force both gates off at once: a low disable input, an active undervoltage-lockout flag, or an OFF command from the upstream three-state decoder. A skip-mode input, when low, keeps the low-side gate off so that the stage runs in diode emulation, while the high side still follows the command. If the command changes while a turn-on is pending, the wait is abandoned and sequencing starts again from the new command. All delays are parameters in clock cycles.

Top module: `dt_gate_seq`

## Requirements
- R1: While reset is held, and on the first cycle after reset, both gate enables are low.
- R2: When the command goes HIGH (cmdIn = 2'b01), gateLow is low after the next clock edge. Call E the first edge at which lsGateLow is sampled high in the waiting state. gateHigh rises ON_DLY edges after E.
- R3: When the command goes LOW (cmdIn = 2'b00) with skipN high, gateHigh is low after the next clock edge. Call S the first edge at which swNodeLow is sampled high in the waiting state. gateLow rises OFF_DLY edges after S.
- R4: Call H the first edge at which hsGateLow is sampled high while the low side is waiting. gateLow rises TIMEOUT edges after H, even if swNodeLow never asserts. If both the R3 path and this backup path are running, the earlier one wins.
- R5: While skipN is low, gateLow stays low whatever the command and flags are. gateHigh still follows a HIGH command as in R2.
- R6: When drvEnable is sampled low, both gate enables are low after the next edge and stay low for as long as it is held low.
- R7: When uvloActive is sampled high, both gate enables are low after the next edge and stay low for as long as it is held high.
- R8: A command with bit 1 set (2'b10 or 2'b11) forces both gate enables low after the next edge.
- R9: If the command changes while a turn-on is pending, that turn-on is cancelled. Its flag and count history is discarded, and the new target is timed from scratch as in R2 or R3.
- R10: gateHigh and gateLow are never high on the same cycle.
- R11: When both gates are off (after a release from disable, lockout or OFF, or after a skipped low phase), any new turn-on still goes through the full flag-plus-delay wait of R2, R3 or R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdIn | input | 2 | Decoded command: 00 LOW, 01 HIGH, 1x OFF |
| skipN | input | 1 | Low selects diode emulation: the low-side gate is held off |
| drvEnable | input | 1 | Low forces both gates off |
| uvloActive | input | 1 | High (supply below threshold) forces both gates off |
| lsGateLow | input | 1 | Sensed flag: the low-side gate is discharged |
| hsGateLow | input | 1 | Sensed flag: the high-side gate is discharged |
| swNodeLow | input | 1 | Sensed flag: the switch node has fallen |
| gateHigh | output | 1 | High-side gate enable |
| gateLow | output | 1 | Low-side gate enable |

## Verification
Assertions inside the controller check, on every cycle, that the two gates never overlap, that each gate rises only after the other was low on the previous cycle, and that disable, lockout, OFF and skip mode take effect on the next edge. Only the bench's scenarios show the exact number of cycles from a flag to a turn-on. The bench sweeps flag arrival times across the on-delay and off-delay and races the switch-node path against the backup timer. It also shows that a cancelled wait restarts its count from zero rather than carrying it over.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

  // command encoding from the three-state decoder
  typedef enum logic [1:0] {
    CMD_LOW  = 2'b00,
    CMD_HIGH = 2'b01,
    CMD_OFFA = 2'b10,
    CMD_OFFB = 2'b11
  } cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LS_ON   = 3'd1,
    ST_WAIT_HS = 3'd2,
    ST_HS_ON   = 3'd3,
    ST_WAIT_LS = 3'd4
  } seq_state_t;

  // strobes from control to the delay datapath
  typedef struct packed {
    logic clear;    // restart all delay channels
    logic runRise;  // high-side turn-on wait is active
    logic runFall;  // low-side turn-on wait is active
  } seq_strobe_t;

  // completion indications back to control
  typedef struct packed {
    logic riseDone;
    logic fallDone;
    logic backupDone;
  } seq_done_t;

endpackage

// File: rtl/gseq_delay.sv
module gseq_delay #(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic flag,
  output logic done
);

  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             seen;

  // the flag is latched once seen, so a short pulse still counts
  assign seen = armed | flag;
  assign done = run & seen & (cnt >= LIM_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (clear) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (run && seen && !done) begin
      armed <= 1'b1;
      if (cnt < LIM_V) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/gseq_timers.sv
module gseq_timers
  import gseq_pkg::*;
#(
  parameter int unsigned ON_DLY  = 4,
  parameter int unsigned OFF_DLY = 4,
  parameter int unsigned TIMEOUT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  seq_strobe_t strobe,
  input  logic        lsGateLow,
  input  logic        swNodeLow,
  input  logic        hsGateLow,
  output seq_done_t   done
);

  localparam int unsigned N_CH   = 3;
  localparam int unsigned MAX_AB = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
  localparam int unsigned MAXLIM = (MAX_AB > TIMEOUT) ? MAX_AB : TIMEOUT;
  localparam int unsigned CNT_W  = $clog2(MAXLIM + 1) + 1;

  logic [N_CH-1:0] chFlag;
  logic [N_CH-1:0] chRun;
  logic [N_CH-1:0] chDone;

  // channel 0: rising wait, channel 1: switch node path, channel 2: backup
  assign chFlag = {hsGateLow, swNodeLow, lsGateLow};
  assign chRun  = {strobe.runFall, strobe.runFall, strobe.runRise};

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam int unsigned LIM = (g == 0) ? ON_DLY : ((g == 1) ? OFF_DLY : TIMEOUT);
    gseq_delay #(
      .LIMIT(LIM),
      .CNT_W(CNT_W)
    ) u_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(strobe.clear),
      .run  (chRun[g]),
      .flag (chFlag[g]),
      .done (chDone[g])
    );
  end

  assign done.riseDone   = chDone[0];
  assign done.fallDone   = chDone[1];
  assign done.backupDone = chDone[2];

endmodule

// File: rtl/gseq_ctrl.sv
module gseq_ctrl
  import gseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cmdIn,
  input  logic        skipN,
  input  logic        drvEnable,
  input  logic        uvloActive,
  input  seq_done_t   done,
  output seq_strobe_t strobe,
  output logic        gateHigh,
  output logic        gateLow
);

  seq_state_t state;
  seq_state_t nextState;
  cmd_t       cmd;
  logic       blocked;

  assign cmd     = cmd_t'(cmdIn);
  assign blocked = !drvEnable || uvloActive || cmdIn[1];

  always_comb begin
    nextState = state;
    if (blocked) begin
      nextState = ST_IDLE;
    end else if (cmd == CMD_HIGH) begin
      case (state)
        ST_HS_ON:   nextState = ST_HS_ON;
        ST_WAIT_HS: nextState = done.riseDone ? ST_HS_ON : ST_WAIT_HS;
        default:    nextState = ST_WAIT_HS;
      endcase
    end else if (!skipN) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_LS_ON:   nextState = ST_LS_ON;
        ST_WAIT_LS: nextState = (done.fallDone || done.backupDone) ? ST_LS_ON : ST_WAIT_LS;
        default:    nextState = ST_WAIT_LS;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    strobe.clear   = (nextState != state);
    strobe.runRise = (state == ST_WAIT_HS);
    strobe.runFall = (state == ST_WAIT_LS);
  end

  assign gateHigh = (state == ST_HS_ON);
  assign gateLow  = (state == ST_LS_ON);

  // R10: no shoot-through
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateHigh && gateLow));
  // R2: high side rises only after the low side was already off
  p_hs_after_ls_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gateHigh) |-> $past(!gateLow));
  // R3: low side rises only after the high side was already off
  p_ls_after_hs_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gateLow) |-> $past(!gateHigh));
  // R6
  p_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !drvEnable |=> (!gateHigh && !gateLow));
  // R7
  p_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uvloActive |=> (!gateHigh && !gateLow));
  // R8
  p_off_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmdIn[1] |=> (!gateHigh && !gateLow));
  // R5
  p_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !skipN |=> !gateLow);

endmodule

// File: rtl/dt_gate_seq.sv
module dt_gate_seq
  import gseq_pkg::*;
#(
  parameter int unsigned ON_DLY  = 4,
  parameter int unsigned OFF_DLY = 4,
  parameter int unsigned TIMEOUT = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmdIn,
  input  logic       skipN,
  input  logic       drvEnable,
  input  logic       uvloActive,
  input  logic       lsGateLow,
  input  logic       hsGateLow,
  input  logic       swNodeLow,
  output logic       gateHigh,
  output logic       gateLow
);

  seq_strobe_t strobe;
  seq_done_t   done;

  gseq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmdIn     (cmdIn),
    .skipN     (skipN),
    .drvEnable (drvEnable),
    .uvloActive(uvloActive),
    .done      (done),
    .strobe    (strobe),
    .gateHigh  (gateHigh),
    .gateLow   (gateLow)
  );

  gseq_timers #(
    .ON_DLY (ON_DLY),
    .OFF_DLY(OFF_DLY),
    .TIMEOUT(TIMEOUT)
  ) u_timers (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .lsGateLow(lsGateLow),
    .swNodeLow(swNodeLow),
    .hsGateLow(hsGateLow),
    .done     (done)
  );

endmodule

// File: tb/dt_gate_seq_tb.sv
module dt_gate_seq_tb;

  localparam int ON  = 2;
  localparam int OFF = 3;
  localparam int TO  = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cmdIn;
  logic       skipN, drvEnable, uvloActive;
  logic       lsGateLow, hsGateLow, swNodeLow;
  logic       gateHigh, gateLow;

  int vectors = 0;
  int fails   = 0;

  always #4 clk = ~clk;

  dt_gate_seq #(.ON_DLY(ON), .OFF_DLY(OFF), .TIMEOUT(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmdIn(cmdIn), .skipN(skipN),
    .drvEnable(drvEnable), .uvloActive(uvloActive),
    .lsGateLow(lsGateLow), .hsGateLow(hsGateLow), .swNodeLow(swNodeLow),
    .gateHigh(gateHigh), .gateLow(gateLow)
  );

  task automatic tick();
    @(posedge clk);
    #2;
    vectors++;
    if (gateHigh && gateLow) begin
      fails++;
      $display("FAIL R10: gh=%b gl=%b expected not both high", gateHigh, gateLow);
    end
  endtask

  task automatic expect2(input string req, input logic eGh, input logic eGl);
    vectors++;
    if (gateHigh !== eGh || gateLow !== eGl) begin
      fails++;
      $display("FAIL %s: gh=%b gl=%b expected gh=%b gl=%b at %0t",
               req, gateHigh, gateLow, eGh, eGl, $time);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // reach steady low-side conduction
  task automatic goLs();
    drvEnable = 1; uvloActive = 0; skipN = 1;
    cmdIn = 2'b00; swNodeLow = 1; hsGateLow = 1; lsGateLow = 0;
    settle(12);
    expect2("R3 setup", 1'b0, 1'b1);
  endtask

  // reach steady high-side conduction
  task automatic goHs();
    drvEnable = 1; uvloActive = 0;
    cmdIn = 2'b01; lsGateLow = 1; hsGateLow = 0; swNodeLow = 0;
    settle(12);
    expect2("R2 setup", 1'b1, 1'b0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; cmdIn = 2'b01; skipN = 1; drvEnable = 1; uvloActive = 0;
    lsGateLow = 1; hsGateLow = 1; swNodeLow = 1;
    // R1: reset holds both gates off
    for (int i = 0; i < 3; i++) begin tick(); expect2("R1 in reset", 1'b0, 1'b0); end
    rst_n = 1;
    // R1/R11: leaving reset, HIGH still goes through the full wait
    for (int j = 0; j < 6; j++) begin
      tick();
      expect2(j == 0 ? "R1 first cycle" : "R11 after reset", j >= 1 + ON, 1'b0);
    end

    // R2: sweep arrival of the low-side-discharged flag
    for (int d = 0; d < 5; d++) begin
      goLs();
      cmdIn = 2'b01;
      for (int j = 0; j < d + ON + 4; j++) begin
        lsGateLow = (j >= 1 + d);
        tick();
        expect2("R2 rise timing", j >= 1 + d + ON, 1'b0);
      end
    end

    // R3/R4: switch-node path against the backup timer
    for (int d = 0; d < 7; d++) begin
      for (int h = 0; h < 2; h++) begin
        int swAt, tSw, tBk, tRise;
        swAt = (d == 6) ? 99 : d;   // d==6: the switch node never reports
        tSw  = 1 + swAt + OFF;
        tBk  = 1 + h + TO;
        tRise = (tSw < tBk) ? tSw : tBk;
        goHs();
        cmdIn = 2'b00; skipN = 1;
        for (int j = 0; j < 13; j++) begin
          hsGateLow = (j >= 1 + h);
          swNodeLow = (j >= 1 + swAt);
          tick();
          expect2((tSw < tBk) ? "R3 fall timing" : "R4 backup timing", 1'b0, j >= tRise);
        end
      end
    end

    // R5: skip mode keeps the low side off, the high side still follows
    skipN = 0;
    goHs();
    cmdIn = 2'b00; swNodeLow = 1; hsGateLow = 1;
    for (int j = 0; j < 9; j++) begin tick(); expect2("R5 skip low phase", 1'b0, 1'b0); end
    cmdIn = 2'b01; lsGateLow = 1;
    for (int j = 0; j < 6; j++) begin tick(); expect2("R5 skip high phase", j >= 1 + ON, 1'b0); end
    skipN = 1; cmdIn = 2'b00;
    for (int j = 0; j < 7; j++) begin tick(); expect2("R5 sync restored", 1'b0, j >= 1 + OFF); end

    // R6: disable from both conduction states, command toggling
    goHs();
    drvEnable = 0;
    for (int j = 0; j < 6; j++) begin
      cmdIn = (j % 2 == 0) ? 2'b00 : 2'b01;
      tick(); expect2("R6 disable from high", 1'b0, 1'b0);
    end
    goLs();
    drvEnable = 0;
    for (int j = 0; j < 4; j++) begin tick(); expect2("R6 disable from low", 1'b0, 1'b0); end
    // R11: release with LOW still waits for the flag plus delay
    drvEnable = 1; cmdIn = 2'b00; swNodeLow = 1; hsGateLow = 1;
    for (int j = 0; j < 7; j++) begin tick(); expect2("R11 release low", 1'b0, j >= 1 + OFF); end

    // R7: lockout
    goHs();
    uvloActive = 1;
    for (int j = 0; j < 5; j++) begin tick(); expect2("R7 lockout from high", 1'b0, 1'b0); end
    goLs();
    uvloActive = 1;
    for (int j = 0; j < 5; j++) begin
      cmdIn = (j % 2 == 0) ? 2'b01 : 2'b00;
      tick(); expect2("R7 lockout from low", 1'b0, 1'b0);
    end
    uvloActive = 0;

    // R8: both OFF codes
    goHs();
    cmdIn = 2'b10;
    for (int j = 0; j < 4; j++) begin tick(); expect2("R8 off 10", 1'b0, 1'b0); end
    goLs();
    cmdIn = 2'b11;
    for (int j = 0; j < 4; j++) begin tick(); expect2("R8 off 11", 1'b0, 1'b0); end

    // R9: rising wait cancelled mid-count, then restarted from zero
    goLs();
    for (int j = 0; j < 9; j++) begin
      case (j)
        0: begin cmdIn = 2'b01; lsGateLow = 0; swNodeLow = 0; hsGateLow = 0; end
        1: lsGateLow = 1;
        2: cmdIn = 2'b00;
        3: cmdIn = 2'b01;
        default: ;
      endcase
      tick();
      expect2("R9 rise restart", j >= 6, 1'b0);
    end
    // R9: falling wait cancelled, the low side never turns on
    goHs();
    for (int j = 0; j < 8; j++) begin
      case (j)
        0: begin cmdIn = 2'b00; swNodeLow = 0; hsGateLow = 0; lsGateLow = 0; end
        1: begin swNodeLow = 1; hsGateLow = 1; end
        2: begin cmdIn = 2'b01; lsGateLow = 1; end
        default: ;
      endcase
      tick();
      expect2("R9 fall cancel", j >= 5, 1'b0);
    end

    summary();
    $finish;
  end

endmodule